// File: doc/BRIEF.md
# Running-Average Background Subtraction Pipeline

This block processes one luminance sample per clock for video foreground detection. Each input beat carries the current pixel together with the stored background mean and variance for the same location. Each output beat returns the refreshed mean, the refreshed variance and a one-bit flag that says whether the pixel still fits the background model. The caller keeps the per-pixel state in frame storage and streams it through the block alongside the live image.

The block has no divider and no square root. The learning weight is a fraction whose denominator is a power of two, so every division becomes a right shift. The fit test compares the squared difference against the squared precision factor times the variance, which removes the need for a square root. A valid bit travels with each beat through seven register stages. An init input, used on the first frame after start-up, seeds the model from the pixel itself.

Top module: `rabg_pipe`

## Requirements
- R1: A beat presented with `in_vld`=1 appears on the outputs with `out_vld`=1 exactly 7 clock edges later. A new beat is accepted every cycle. A cycle with `in_vld`=0 yields `out_vld`=0 seven edges later.
- R2: For a non-init beat, `out_bg` = (K·bg + (2^SHIFT − K)·pix) >> SHIFT, with K = `K_WT`.
- R3: For a non-init beat, `out_var` = (K·var + (2^SHIFT − K)·d²) >> SHIFT, where d = pix − bg uses the incoming background. A result above 2^VW − 1 is clamped to 2^VW − 1.
- R4: For a non-init beat, `out_match` = 1 when d² < `LAMBDA_SQ`·var, using the incoming variance, and 0 otherwise.
- R5: For a beat with `in_init`=1, `out_bg` equals the pixel, `out_var` equals `VAR_FLOOR`, and `out_match`=1.
- R6: While `rst_n` is low, `out_vld` is 0. Beats in flight when reset is asserted never appear at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input beat valid |
| in_init | input | 1 | Seed the model from this pixel |
| in_pix | input | PW | Current luminance sample |
| in_bg | input | PW | Stored background mean |
| in_var | input | VW | Stored background variance |
| out_vld | output | 1 | Output beat valid |
| out_bg | output | PW | Updated background mean |
| out_var | output | VW | Updated, saturated variance |
| out_match | output | 1 | 1 = pixel fits the background |

## Verification
Every result belongs to the beat captured seven rising edges earlier, and the mean, variance and flag all emerge in that same cycle. The bench drives inputs on the falling edge. It keeps a seven-deep line of expected results computed from the equations. At each falling edge it compares the outputs with the entry that was pushed seven drives before. Bubble cycles and a mid-stream reset are checked in the same way, with invalid entries expected in place of the lost beats.

// File: rtl/rabg_pipe.sv
module rabg_pipe #(
  parameter int PW        = 10,
  parameter int VW        = 16,
  parameter int SHIFT     = 7,
  parameter int K_WT      = 96,
  parameter int LAMBDA_SQ = 9,
  parameter int VAR_FLOOR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_init,
  input  logic [PW-1:0] in_pix,
  input  logic [PW-1:0] in_bg,
  input  logic [VW-1:0] in_var,
  output logic          out_vld,
  output logic [PW-1:0] out_bg,
  output logic [VW-1:0] out_var,
  output logic          out_match
);
  localparam int SQW = 2 * PW;
  localparam int MXW = (SQW > VW) ? SQW : VW;
  localparam int PRW = MXW + SHIFT + 1;
  localparam int LVW = MXW + 9;
  localparam logic [PRW-1:0] KC   = PRW'(K_WT);
  localparam logic [PRW-1:0] NKC  = PRW'((1 << SHIFT) - K_WT);
  localparam logic [LVW-1:0] LC   = LVW'(LAMBDA_SQ);
  localparam logic [PRW-1:0] VCAP = {{(PRW-VW){1'b0}}, {VW{1'b1}}};

  logic          v1, v2, v3, v4, v5, v6;
  logic          i1, i2, i3, i4, i5, i6;
  logic [PW-1:0] p1, p2, p3, p4, p5, p6;
  logic [PW-1:0] b1, b2, b3;
  logic [VW-1:0] q1, q2, q3;
  logic [PW:0]   d2;
  logic [PW-1:0] a3;
  logic [SQW-1:0] sq4;
  logic [PRW-1:0] kb4, np4, kv4, bs5, kv5, ns5, vs6;
  logic [LVW-1:0] lv4;
  logic          lt5, lt6;
  logic [PW-1:0] bn6;
  logic [PRW-1:0] vsh;

  assign vsh = vs6 >> SHIFT;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {v1, v2, v3, v4, v5, v6, out_vld} <= '0;
    else        {v1, v2, v3, v4, v5, v6, out_vld} <= {in_vld, v1, v2, v3, v4, v5, v6};

  always_ff @(posedge clk) begin
    i1 <= in_vld & in_init; p1 <= in_pix; b1 <= in_bg; q1 <= in_var;
    i2 <= i1; p2 <= p1; b2 <= b1; q2 <= q1;
    d2 <= {1'b0, p1} - {1'b0, b1};
    i3 <= i2; p3 <= p2; b3 <= b2; q3 <= q2;
    a3 <= d2[PW] ? PW'(-d2) : PW'(d2);
    i4 <= i3; p4 <= p3;
    sq4 <= SQW'(a3) * SQW'(a3);
    kb4 <= KC * PRW'(b3);
    np4 <= NKC * PRW'(p3);
    kv4 <= KC * PRW'(q3);
    lv4 <= LC * LVW'(q3);
    i5 <= i4; p5 <= p4;
    bs5 <= kb4 + np4;
    ns5 <= NKC * PRW'(sq4);
    kv5 <= kv4;
    lt5 <= LVW'(sq4) < lv4;
    i6 <= i5; p6 <= p5;
    vs6 <= kv5 + ns5;
    bn6 <= PW'(bs5 >> SHIFT);
    lt6 <= lt5;
    out_bg    <= i6 ? p6 : bn6;
    out_var   <= i6 ? VW'(VAR_FLOOR) : ((vsh > VCAP) ? {VW{1'b1}} : VW'(vsh));
    out_match <= i6 | lt6;
  end

  logic [2:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             age <= '0;
    else if (age != 3'd7)   age <= age + 3'd1;

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd7) |-> (out_vld == $past(in_vld, 7)));
  a_r2_steady_bg: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd7 && out_vld && $past(in_pix == in_bg, 7)) |-> (out_bg == $past(in_pix, 7)));
  a_r3_zero_diff_var: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd7 && out_vld && $past(in_pix == in_bg && !in_init, 7)) |-> (out_var <= $past(in_var, 7)));
  a_r4_zero_diff_match: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd7 && out_vld && $past(in_pix == in_bg && in_var != '0, 7)) |-> out_match);
  a_r5_init_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 3'd7 && out_vld && $past(in_init, 7))
      |-> (out_var == VW'(VAR_FLOOR) && out_bg == $past(in_pix, 7) && out_match));
endmodule

// File: tb/sim_rabg_pipe.sv
module sim_rabg_pipe;
  localparam int PW = 10, VW = 16, SHIFT = 7, K = 96, LSQ = 9, FLOOR = 16;
  localparam longint NN = 1 << SHIFT;
  localparam longint VMAX = (1 << VW) - 1;

  logic clk = 0, rst_n = 0;
  logic in_vld = 0, in_init = 0;
  logic [PW-1:0] in_pix = 0, in_bg = 0;
  logic [VW-1:0] in_var = 0;
  logic out_vld, out_match;
  logic [PW-1:0] out_bg;
  logic [VW-1:0] out_var;

  rabg_pipe #(.PW(PW), .VW(VW), .SHIFT(SHIFT), .K_WT(K), .LAMBDA_SQ(LSQ), .VAR_FLOOR(FLOOR)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_init(in_init), .in_pix(in_pix),
    .in_bg(in_bg), .in_var(in_var), .out_vld(out_vld), .out_bg(out_bg),
    .out_var(out_var), .out_match(out_match));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit     hv[7], hi[7], hm[7];
  longint hb[7], hq[7];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int j = 0; j < 7; j++) hv[j] = 0;
  endtask

  task automatic step(bit v, bit ini, int pix, int bg, int vr);
    longint d, sq, bn, vn;
    @(negedge clk);
    if (hv[6]) begin
      chk(out_vld == 1, "R1", out_vld, 1);
      if (hi[6]) begin
        chk(out_bg == hb[6] && out_var == hq[6] && out_match == 1, "R5", out_var, hq[6]);
      end else begin
        chk(out_bg == hb[6], "R2", out_bg, hb[6]);
        chk(out_var == hq[6], "R3", out_var, hq[6]);
        chk(out_match == hm[6], "R4", out_match, hm[6]);
      end
    end else chk(out_vld == 0, "R1", out_vld, 0);
    for (int j = 6; j > 0; j--) begin
      hv[j] = hv[j-1]; hi[j] = hi[j-1]; hb[j] = hb[j-1]; hq[j] = hq[j-1]; hm[j] = hm[j-1];
    end
    d = longint'(pix) - longint'(bg);
    sq = d * d;
    bn = (K * longint'(bg) + (NN - K) * longint'(pix)) >> SHIFT;
    vn = (K * longint'(vr) + (NN - K) * sq) >> SHIFT;
    if (vn > VMAX) vn = VMAX;
    hv[0] = v; hi[0] = ini;
    hb[0] = ini ? pix : bn;
    hq[0] = ini ? FLOOR : vn;
    hm[0] = ini ? 1'b1 : (sq < LSQ * longint'(vr));
    in_vld = v; in_init = ini;
    in_pix = PW'(pix); in_bg = PW'(bg); in_var = VW'(vr);
  endtask

  task automatic drain();
    for (int j = 0; j < 8; j++) step(0, 0, 0, 0, 0);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk(out_vld == 0, "R6 reset", out_vld, 0);
    rst_n = 1;
    clear_hist();
  endtask

  task automatic t_init_frame();
    step(1, 1, 300, 17, 999);
    step(1, 1, 0, 1023, 5);
    step(1, 1, 1023, 0, 0);
    drain();
  endtask

  task automatic t_steady();
    for (int j = 0; j < 10; j++) step(1, 0, 100 + j * 90, 100 + j * 90, 50 + j);
    drain();
  endtask

  task automatic t_threshold_edge();
    step(1, 0, 110, 100, 11);
    step(1, 0, 110, 100, 12);
    step(1, 0, 90, 100, 12);
    step(1, 0, 130, 100, 100);
    step(1, 0, 131, 100, 100);
    drain();
  endtask

  task automatic t_saturation();
    step(1, 0, 1023, 0, 65535);
    step(1, 0, 0, 1023, 65535);
    step(1, 0, 1023, 0, 0);
    step(1, 0, 0, 0, 0);
    drain();
  endtask

  task automatic t_bubbles();
    for (int j = 0; j < 24; j++)
      step(j % 3 != 1, 0, (j * 37) % 1024, (j * 53) % 1024, j * 211);
    drain();
  endtask

  task automatic t_mid_reset();
    for (int j = 0; j < 5; j++) step(1, 0, j * 10, 40, 20);
    @(negedge clk);
    rst_n = 0;
    in_vld = 0;
    @(negedge clk);
    chk(out_vld == 0, "R6 mid", out_vld, 0);
    clear_hist();
    rst_n = 1;
    drain();
  endtask

  task automatic t_random();
    for (int j = 0; j < 400; j++)
      step(($urandom % 5) != 0, ($urandom % 17) == 0, $urandom % 1024, $urandom % 1024, $urandom % 65536);
    drain();
  endtask

  initial begin
    clear_hist();
    t_reset_state();
    t_init_frame();
    t_steady();
    t_threshold_edge();
    t_saturation();
    t_bubbles();
    t_mid_reset();
    t_random();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule